// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 52-bit physical address. It reads one 64-bit translation entry from each of four table levels through a single memory port. The port has a request/acknowledge handshake with variable latency. The first table lives at a page number held in `root_ppn`. Every entry that is passed through is checked for presence and for the access rights of the request, which covers write, user mode and instruction fetch. An entry that is used has its accessed flag set in memory if the flag was clear. For a write, the last entry also has its dirty flag set. The walk ends with either a physical address or a fault code.

A requester raises `req_valid` while `req_ready` is high. It then waits for the single-cycle `done` pulse, which carries `fault`, `fault_cause` and `paddr`.

The controller has five states:

- **IDLE**: waits for a request.
- **READ**: fetches the entry of the current level.
- **CHECK**: judges the fetched entry.
- **UPDATE**: writes the entry back with its flags set.
- **DONE**: presents the result for one cycle.

The transitions are:

- IDLE→READ on a request.
- READ→CHECK on acknowledge.
- CHECK→DONE on a fault, or on the last level when no write-back is needed.
- CHECK→UPDATE when a flag must be set.
- CHECK→READ to descend a level.
- UPDATE→READ or UPDATE→DONE on acknowledge, depending on the level.
- DONE→IDLE always.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `done` and `mem_req` are 0. No memory request is made while idle.
- R2: Level k (k = 1..4) reads the 8-byte entry at {table page number, index, 3'b000}. The indices are taken from virtual address bits 47:39, 38:30, 29:21 and 20:12 for levels 1 to 4 in that order. The level-1 table page number is `root_ppn`.
- R3: Entry bits 51:12 give the table page number of the next level. In the level-4 entry they give the result page number, and `paddr` = {bits 51:12, vaddr[11:0]}.
- R4: An entry with bit 0 (present) clear stops the walk with fault cause 0 (not present). That entry is not written.
- R5: A write request through any entry with bit 1 (writable) clear faults with cause 1.
- R6: A user request through any entry with bit 2 (user allowed) clear faults with cause 2.
- R7: A fetch request through any entry with bit 63 (no execute) set faults with cause 3.
- R8: Entries are judged one level at a time, so the first failing level ends the walk. Within one entry the priority is not-present, then write, then user, then fetch.
- R9: A passing entry with bit 5 (accessed) clear is written back with bit 5 set before the next access. All its other bits are unchanged. When bit 5 is already set, no write is made.
- R10: On a write request, the level-4 entry is written with bit 6 (dirty) set as well. Upper entries never get bit 6 from the walker.
- R11: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack`. `mem_rdata` is taken in the acknowledge cycle, after any number of wait cycles.
- R12: `done` is high for exactly one cycle per walk. On a fault, `paddr` is 0. Without a fault, `fault_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_ppn | input | 40 | Page number of the level-1 table |
| req_valid | input | 1 | Start a walk |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 48 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| req_exec | input | 1 | Access is an instruction fetch |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write of `mem_wdata` |
| mem_addr | output | 52 | Byte address of the entry |
| mem_wdata | output | 64 | Updated entry to store |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 64 | Entry read, valid with `mem_ack` |
| done | output | 1 | Result valid, one cycle |
| fault | output | 1 | Walk ended in a fault |
| fault_cause | output | 2 | 0 not present, 1 write, 2 user, 3 fetch |
| paddr | output | 52 | Physical address |

## Verification
The bench repeats a walk over the same address after its flags have been set. This checks that a design which writes unconditionally, or never writes, shows an extra or a missing memory access. A write is issued to a page whose upper entries already carry the accessed flag, which exposes a dirty flag put on the wrong level. Faults are placed at a middle level, and a single entry is made to break several rules at once. A wrong priority shows up as a wrong cause, and a write to the failing entry shows up as an unexpected access. Acknowledge latency varies from zero to three wait cycles, which catches data taken too early or an address that moves while waiting.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;
    localparam int BIT_ACCESS  = 5;
    localparam int BIT_DIRTY   = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CHECK,
        ST_UPDATE,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        CAUSE_NOT_PRESENT = 2'd0,
        CAUSE_WRITE_PROT  = 2'd1,
        CAUSE_USER_PROT   = 2'd2,
        CAUSE_EXEC_DIS    = 2'd3
    } fault_cause_e;
endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int PPN_W  = 40
) (
    input  logic [IDX_W*LEVELS-1:0]    vpn,
    input  logic [$clog2(LEVELS)-1:0]  level,
    input  logic [PPN_W-1:0]           table_ppn,
    output logic [PPN_W+OFF_W-1:0]     entry_addr
);
    localparam int ENT_W = OFF_W - IDX_W;

    logic [IDX_W-1:0] idx_by_lvl [LEVELS];

    // level 0 takes the most significant field
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_by_lvl[g] = vpn[IDX_W*(LEVELS-g)-1 -: IDX_W];
    end

    assign entry_addr = {table_ppn, idx_by_lvl[level], {ENT_W{1'b0}}};
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
    import pt_walk_pkg::*;
#(
    parameter int PTE_W = 64
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_write,
    input  logic             is_user,
    input  logic             is_exec,
    input  logic             is_leaf,
    output logic             pass,
    output fault_cause_e     cause,
    output logic [PTE_W-1:0] pte_upd,
    output logic             need_upd
);
    localparam int BIT_NOEXEC = PTE_W - 1;

    always_comb begin
        pass  = 1'b0;
        cause = CAUSE_NOT_PRESENT;
        if (!pte[BIT_PRESENT])
            cause = CAUSE_NOT_PRESENT;
        else if (is_write && !pte[BIT_WRITE])
            cause = CAUSE_WRITE_PROT;
        else if (is_user && !pte[BIT_USER])
            cause = CAUSE_USER_PROT;
        else if (is_exec && pte[BIT_NOEXEC])
            cause = CAUSE_EXEC_DIS;
        else
            pass = 1'b1;
    end

    always_comb begin
        pte_upd             = pte;
        pte_upd[BIT_ACCESS] = 1'b1;
        if (is_leaf && is_write)
            pte_upd[BIT_DIRTY] = 1'b1;
    end

    assign need_upd = (pte_upd != pte);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int PPN_W  = 40,
    parameter int PTE_W  = 64,
    localparam int VA_W  = IDX_W * LEVELS + OFF_W,
    localparam int PA_W  = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PPN_W-1:0] root_ppn,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    input  logic             req_exec,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_ack,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic             done,
    output logic             fault,
    output logic [1:0]       fault_cause,
    output logic [PA_W-1:0]  paddr
);
    localparam int LVL_W = $clog2(LEVELS);

    walk_state_e      state_q, state_d;
    logic [VA_W-1:0]  va_q;
    logic             wr_q, usr_q, exe_q;
    logic [LVL_W-1:0] lvl_q;
    logic [PPN_W-1:0] base_q;
    logic [PTE_W-1:0] pte_q;
    logic             fault_q;
    fault_cause_e     cause_q;
    logic [PA_W-1:0]  paddr_q;

    logic             is_leaf, chk_pass, need_upd, advance;
    fault_cause_e     chk_cause;
    logic [PTE_W-1:0] pte_upd;
    logic [PA_W-1:0]  entry_addr;

    assign is_leaf = (lvl_q == LVL_W'(LEVELS - 1));

    pt_entry_addr #(
        .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PPN_W(PPN_W)
    ) u_addr (
        .vpn        (va_q[VA_W-1:OFF_W]),
        .level      (lvl_q),
        .table_ppn  (base_q),
        .entry_addr (entry_addr)
    );

    pt_perm_check #(.PTE_W(PTE_W)) u_perm (
        .pte      (pte_q),
        .is_write (wr_q),
        .is_user  (usr_q),
        .is_exec  (exe_q),
        .is_leaf  (is_leaf),
        .pass     (chk_pass),
        .cause    (chk_cause),
        .pte_upd  (pte_upd),
        .need_upd (need_upd)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_READ;
            ST_READ:   if (mem_ack) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!chk_pass)     state_d = ST_DONE;
                else if (need_upd) state_d = ST_UPDATE;
                else if (is_leaf)  state_d = ST_DONE;
                else               state_d = ST_READ;
            end
            ST_UPDATE: if (mem_ack) state_d = is_leaf ? ST_DONE : ST_READ;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign advance = ((state_q == ST_CHECK) && chk_pass && !need_upd) ||
                     ((state_q == ST_UPDATE) && mem_ack);

    // walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q    <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            exe_q   <= 1'b0;
            lvl_q   <= '0;
            base_q  <= '0;
            pte_q   <= '0;
            fault_q <= 1'b0;
            cause_q <= CAUSE_NOT_PRESENT;
            paddr_q <= '0;
        end else begin
            if ((state_q == ST_IDLE) && req_valid) begin
                va_q    <= req_vaddr;
                wr_q    <= req_write;
                usr_q   <= req_user;
                exe_q   <= req_exec;
                lvl_q   <= '0;
                base_q  <= root_ppn;
                fault_q <= 1'b0;
                cause_q <= CAUSE_NOT_PRESENT;
                paddr_q <= '0;
            end
            if ((state_q == ST_READ) && mem_ack)
                pte_q <= mem_rdata;
            if ((state_q == ST_CHECK) && !chk_pass) begin
                fault_q <= 1'b1;
                cause_q <= chk_cause;
                paddr_q <= '0;
            end
            if (advance) begin
                if (is_leaf)
                    paddr_q <= {pte_q[OFF_W +: PPN_W], va_q[OFF_W-1:0]};
                else begin
                    base_q <= pte_q[OFF_W +: PPN_W];
                    lvl_q  <= lvl_q + LVL_W'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        mem_req     = (state_q == ST_READ) || (state_q == ST_UPDATE);
        mem_we      = (state_q == ST_UPDATE);
        mem_addr    = entry_addr;
        mem_wdata   = pte_upd;
        done        = (state_q == ST_DONE);
        fault       = done && fault_q;
        fault_cause = done ? cause_q : CAUSE_NOT_PRESENT;
        paddr       = done ? paddr_q : '0;
    end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
    import pt_walk_pkg::*;
#(
    parameter int PA_W  = 52,
    parameter int PTE_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic [PA_W-1:0]  mem_addr,
    input logic [PTE_W-1:0] mem_wdata,
    input logic             mem_ack,
    input logic             done,
    input logic             fault,
    input logic [PA_W-1:0]  paddr
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req && !done); // R1

    AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && req_valid |=> mem_req && !mem_we); // R2

    AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[2:0] == 3'b000); // R2

    AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[BIT_ACCESS] && mem_wdata[BIT_PRESENT]); // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata)); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready); // R12

    AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> paddr == '0); // R12
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, req_valid, req_ready, req_write, req_user, req_exec;
    logic [39:0] root_ppn;
    logic [47:0] req_vaddr;
    logic        mem_req, mem_we, mem_ack, done, fault;
    logic [51:0] mem_addr, paddr;
    logic [63:0] mem_wdata, mem_rdata;
    logic [1:0]  fault_cause;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .root_ppn(root_ppn),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .req_exec(req_exec),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .fault_cause(fault_cause), .paddr(paddr)
    );

    localparam logic [63:0] F_P  = 64'h1;
    localparam logic [63:0] F_RW = 64'h2;
    localparam logic [63:0] F_US = 64'h4;
    localparam logic [63:0] F_EX = 64'h18;   // write-through and cache-disable kept
    localparam logic [63:0] F_G  = 64'h100;
    localparam logic [63:0] F_XD = 64'h8000_0000_0000_0000;
    localparam logic [63:0] F_OK = F_P | F_RW | F_US | F_EX | F_G;

    typedef struct packed {
        logic        we;
        logic [51:0] addr;
        logic [63:0] data;
    } acc_t;

    int          checks = 0;
    int          errors = 0;
    logic [63:0] mem [logic [51:0]];
    acc_t        exp_q [$];
    logic        exp_fault;
    logic [1:0]  exp_cause;
    logic [51:0] exp_pa;
    bit          walking = 1'b0;

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [63:0] rdmem(logic [51:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'h0;
    endfunction

    // reference walk: expected access list and result
    task automatic model(logic [47:0] va, bit w, bit u, bit x);
        logic [39:0] base;
        logic [63:0] pte, upd;
        logic [51:0] a;
        base      = root_ppn;
        exp_fault = 1'b0;
        exp_cause = 2'd0;
        exp_pa    = 52'h0;
        for (int l = 0; l < 4; l++) begin
            a = {base, va[47-9*l -: 9], 3'b000};
            exp_q.push_back('{we: 1'b0, addr: a, data: 64'h0});
            pte = rdmem(a);
            if (!pte[0])          begin exp_fault = 1'b1; exp_cause = 2'd0; return; end
            if (w && !pte[1])     begin exp_fault = 1'b1; exp_cause = 2'd1; return; end
            if (u && !pte[2])     begin exp_fault = 1'b1; exp_cause = 2'd2; return; end
            if (x && pte[63])     begin exp_fault = 1'b1; exp_cause = 2'd3; return; end
            upd    = pte;
            upd[5] = 1'b1;
            if (l == 3 && w) upd[6] = 1'b1;
            if (upd != pte) exp_q.push_back('{we: 1'b1, addr: a, data: upd});
            base = pte[51:12];
        end
        exp_pa = {base, va[11:0]};
    endtask

    // build four entries for va; flags per level, leaf page number
    task automatic map(logic [47:0] va, logic [63:0] f0, logic [63:0] f1,
                       logic [63:0] f2, logic [63:0] f3, logic [39:0] leaf);
        logic [39:0] t [4];
        logic [63:0] f [4];
        logic [39:0] nxt;
        f[0] = f0; f[1] = f1; f[2] = f2; f[3] = f3;
        t[0] = root_ppn;
        for (int l = 1; l < 4; l++)
            t[l] = 40'h20000 + 40'(va[47:39]) * 40'd8 + 40'(l);
        for (int l = 0; l < 4; l++) begin
            nxt = (l == 3) ? leaf : t[l+1];
            mem[{t[l], va[47-9*l -: 9], 3'b000}] = f[l] | {12'h0, nxt, 12'h0};
        end
    endtask

    // memory responder: variable latency, compares every access (R2, R9, R10, R11)
    initial begin : mem_side
        int          wait_cnt;
        int          seq;
        logic [51:0] first_addr;
        bit          seen;
        acc_t        e;
        wait_cnt  = 0;
        seq       = 0;
        seen      = 1'b0;
        first_addr = 52'h0;
        mem_ack   = 1'b0;
        mem_rdata = 64'h0;
        forever begin
            @(negedge clk);
            if (!walking && rst_n) chk("R12 no result while idle", 64'(done), 64'(0));
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (!seen) begin seen = 1'b1; first_addr = mem_addr; end
                if (wait_cnt > 0) wait_cnt--;
                else begin
                    chk("R11 address held while waiting", 64'(mem_addr), 64'(first_addr));
                    if (exp_q.size() == 0)
                        chk("R2 unexpected access", 64'(1), 64'(0));
                    else begin
                        e = exp_q.pop_front();
                        chk("R2 entry address", 64'(mem_addr), 64'(e.addr));
                        chk("R9 access kind", 64'(mem_we), 64'(e.we));
                        if (mem_we && e.we) chk("R9 R10 written entry", mem_wdata, e.data);
                    end
                    if (mem_we) mem[mem_addr] = mem_wdata;
                    mem_rdata = rdmem(mem_addr);
                    mem_ack   = 1'b1;
                    seen      = 1'b0;
                    seq++;
                    wait_cnt  = seq % 4;
                end
            end
        end
    end

    task automatic run(string tag, logic [47:0] va, bit w, bit u, bit x);
        int n;
        model(va, w, u, x);
        @(negedge clk);
        chk({tag, " R1 ready"}, 64'(req_ready), 64'(1));
        req_vaddr = va;
        req_write = w;
        req_user  = u;
        req_exec  = x;
        req_valid = 1'b1;
        walking   = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        if (n >= 2000) begin
            chk({tag, " R12 walk finished"}, 64'(0), 64'(1));
            exp_q.delete();
        end else begin
            chk({tag, " R12 fault"}, 64'(fault), 64'(exp_fault));
            chk({tag, " R12 cause"}, 64'(fault_cause), 64'(exp_cause));
            chk({tag, " R3 paddr"}, 64'(paddr), 64'(exp_pa));
            chk({tag, " R9 all accesses made"}, 64'(exp_q.size()), 64'(0));
        end
        @(negedge clk);
        walking = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [47:0] va;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_vaddr = 48'h0;
        req_write = 1'b0;
        req_user  = 1'b0;
        req_exec  = 1'b0;
        root_ppn  = 40'h00100;
        repeat (3) @(negedge clk);
        chk("R1 reset ready", 64'(req_ready), 64'(1));
        chk("R1 reset done", 64'(done), 64'(0));
        chk("R1 reset mem_req", 64'(mem_req), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R9: fresh mapping, all accessed flags clear
        va = {9'd1, 9'd2, 9'd3, 9'd4, 12'habc};
        map(va, F_OK, F_OK, F_OK, F_OK, 40'hABCDE);
        run("first walk R9", va, 0, 1, 0);
        run("repeat walk R9 no writes", va, 0, 1, 0);
        run("write walk R10 dirty", va, 1, 1, 0);
        run("second write R10 no writes", va, 1, 1, 0);

        // R4: level 3 not present
        va = {9'd5, 9'd17, 9'd300, 9'd511, 12'h004};
        map(va, F_OK, F_OK, F_OK & ~F_P, F_OK, 40'h12345);
        run("R4 not present mid", va, 0, 0, 0);

        // R5: leaf read-only
        va = {9'd6, 9'd0, 9'd7, 9'd8, 12'hff8};
        map(va, F_OK, F_OK, F_OK, F_OK & ~F_RW, 40'h00777);
        run("R5 write read-only", va, 1, 0, 0);
        run("R5 read of read-only ok", va, 0, 0, 0);

        // R6: level 2 supervisor-only
        va = {9'd7, 9'd9, 9'd10, 9'd11, 12'h100};
        map(va, F_OK, F_OK & ~F_US, F_OK, F_OK, 40'hFFFFF);
        run("R6 user to supervisor", va, 0, 1, 0);
        run("R6 supervisor ok", va, 0, 0, 0);

        // R7: level 1 no-execute
        va = {9'd8, 9'd12, 9'd13, 9'd14, 12'h020};
        map(va, F_OK | F_XD, F_OK, F_OK, F_OK, 40'h0F0F0);
        run("R7 fetch refused", va, 0, 0, 1);
        run("R7 data read ok", va, 0, 0, 0);

        // R8: one entry breaking several rules
        va = {9'd9, 9'd15, 9'd16, 9'd17, 12'h7ff};
        map(va, F_OK, F_OK, F_OK, (F_OK & ~F_RW & ~F_US) | F_XD, 40'hCAFE0);
        run("R8 write beats user", va, 1, 1, 1);
        run("R8 user beats fetch", va, 0, 1, 1);
        run("R8 fetch alone", va, 0, 0, 1);

        // R8: upper level fails before leaf rule
        va = {9'd10, 9'd18, 9'd19, 9'd20, 12'h3c0};
        map(va, F_OK, F_OK & ~F_US, F_OK & ~F_RW, F_OK, 40'h55555);
        run("R8 earlier level wins", va, 1, 1, 0);

        // R3 R11: high root page and high indices
        root_ppn = 40'hFF_FFFF_F000;
        va = {9'd511, 9'd256, 9'd1, 9'd255, 12'h001};
        map(va, F_OK, F_OK, F_OK, F_OK, 40'h8000000001);
        run("R3 high root", va, 1, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule